// File: doc/BRIEF.md
# Status-Qualified I/O Port Decoder

This block turns the high byte of the address seen during an 8080-style I/O bus cycle into active-low, one-hot select strobes for a bank of eight input ports and a bank of eight output ports. The ports occupy addresses F8h through FFh. The decoder responds only when address bits 15 to 11 are all ones. Bits 10 to 8 then pick the individual port.

Each direction has its own bus qualifiers. An input strobe requires both the input-cycle status and the data-bus-in strobe. An output strobe requires both the output-cycle status and the active-low write strobe. A separate flag marks a read from the lower half of the input bank (F8h to FBh) as an interrupt-group access.

The block also supplies the enable for a neighbouring memory page decoder. That enable drops during any I/O status cycle. When a strap input allows it, an interrupt-acknowledge cycle silences both the I/O strobes and the memory page enable. The block is purely combinational.

Top module: `status_io_port_decoder`

## Requirements
- R1: No strobe is asserted unless `addr_hi[7:3]` (address bits 15..11) equals 5'b11111.
- R2: When a bank is enabled, exactly one strobe of that bank is low. It is bit `addr_hi[2:0]`, so port F8h maps to bit 0 and port FFh maps to bit 7. All other strobes stay high.
- R3: `in_strobe_n` can be asserted only while `st_inp` = 1 and `dbin` = 1. If either is 0, all eight input strobes are 8'hFF.
- R4: `out_strobe_n` can be asserted only while `st_out` = 1 and `wr_n` = 0. If `st_out` is 0 or `wr_n` is 1, all eight output strobes are 8'hFF.
- R5: `int_grp_sel` is 1 exactly when an input strobe is asserted with `addr_hi[2:0]` in 0..3 (ports F8h to FBh). It is 0 for output cycles and for input ports FCh to FFh.
- R6: When `inta_gate_en` = 1 and `inta` = 1, every strobe is high, `int_grp_sel` = 0 and `mem_page_en` = 0. When `inta_gate_en` = 0, `inta` has no effect on any output.
- R7: `mem_page_en` = 1 exactly when `st_inp` = 0, `st_out` = 0 and the acknowledge block of R6 is inactive.
- R8: With all qualifiers inactive (`st_inp` = 0, `st_out` = 0, `dbin` = 0, `wr_n` = 1, `inta` = 0), both strobe banks are 8'hFF and `int_grp_sel` = 0, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_hi | input | 8 | Address bits 15..8 of the current bus cycle |
| st_inp | input | 1 | Status: input cycle in progress (active high) |
| st_out | input | 1 | Status: output cycle in progress (active high) |
| dbin | input | 1 | Data-bus-in strobe (active high) |
| wr_n | input | 1 | Write strobe (active low) |
| inta | input | 1 | Interrupt-acknowledge status (active high) |
| inta_gate_en | input | 1 | Strap: let interrupt acknowledge disable the decoders |
| in_strobe_n | output | 8 | Input port selects F8h..FFh, active low, one-hot |
| out_strobe_n | output | 8 | Output port selects F8h..FFh, active low, one-hot |
| int_grp_sel | output | 1 | Input access to ports F8h..FBh (active high) |
| mem_page_en | output | 1 | Enable for the memory page decoder (active high) |

## Verification
The checks are combinational implications evaluated whenever an input changes. Because of this, they assume the inputs are stable two-state values and never X or Z. They also assume the address and the qualifiers can take any combination, including the two status flags together. The stimulus honours these assumptions. It drives every input at the falling clock edge and samples a quarter period later. It walks all 256 high-address values across every combination of the four bus qualifiers and the two acknowledge inputs. Directed cases cover bank edges, partial qualification and the strap.

// File: rtl/iodec_pkg.sv
// Package: shared types for the status-qualified I/O port decoder.
// Assumes: status and strobe signals are sampled as plain two-state levels.
package iodec_pkg;

    // Snapshot of the processor status and bus strobes for one cycle
    typedef struct packed {
        logic st_inp;
        logic st_out;
        logic dbin;
        logic wr_n;
    } bus_qual_t;

    // Input direction is qualified by input status and the read strobe
    function automatic logic read_qualified(bus_qual_t q);
        return q.st_inp && q.dbin;
    endfunction

    // Output direction is qualified by output status and the low write strobe
    function automatic logic write_qualified(bus_qual_t q);
        return q.st_out && !q.wr_n;
    endfunction

endpackage

// File: rtl/iodec_addr_match.sv
// Module: iodec_addr_match
// Splits the high address byte into a bank-match flag (all upper bits one)
// and the port index carried by the low SEL_W bits.
// Assumes: the port bank sits at the very top of the address space.
module iodec_addr_match #(
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bank_hit,
    output logic [SEL_W-1:0]  port_sel
);
    localparam int MATCH_W = ADDR_W - SEL_W;

    logic [MATCH_W-1:0] upper_bits;

    // Separate the match field from the index field
    always_comb begin
        upper_bits = addr[ADDR_W-1:SEL_W];
        port_sel   = addr[SEL_W-1:0];
    end

    // Bank matches only when every upper bit is one
    always_comb begin
        bank_hit = &upper_bits;
    end
endmodule

// File: rtl/iodec_qualify.sv
// Module: iodec_qualify
// Combines bank match, bus qualifiers and the interrupt-acknowledge block
// into per-direction enables plus the memory page decoder enable.
// Assumes: inta is only honoured when the strap input allows it.
module iodec_qualify
    import iodec_pkg::*;
(
    input  bus_qual_t qual,
    input  logic      bank_hit,
    input  logic      inta,
    input  logic      inta_gate_en,
    output logic      rd_en,
    output logic      wr_en,
    output logic      mem_en
);
    logic ack_block;

    // Acknowledge cycle blocks decoding only when strapped in
    always_comb begin
        ack_block = inta_gate_en && inta;
    end

    // Per-direction enables from match, qualifiers and block
    always_comb begin
        rd_en = bank_hit && read_qualified(qual)  && !ack_block;
        wr_en = bank_hit && write_qualified(qual) && !ack_block;
    end

    // Memory page decoder runs only outside I/O and blocked cycles
    always_comb begin
        mem_en = !qual.st_inp && !qual.st_out && !ack_block;
    end
endmodule

// File: rtl/iodec_strobe_gen.sv
// Module: iodec_strobe_gen
// Expands a port index into 2**SEL_W active-low strobes, one-hot when
// enabled and all high otherwise.
// Assumes: sel is stable whenever en is high.
module iodec_strobe_gen #(
    parameter int SEL_W = 3
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [(1<<SEL_W)-1:0] strobe_n
);
    localparam int N_PORTS = 1 << SEL_W;

    // One comparator per strobe line
    for (genvar g = 0; g < N_PORTS; g++) begin : g_line
        assign strobe_n[g] = !(en && (sel == SEL_W'(g)));
    end
endmodule

// File: rtl/status_io_port_decoder.sv
// Module: status_io_port_decoder (top)
// Decodes the high address byte of an I/O cycle into input and output port
// strobes, flags the interrupt port group and drives the memory page enable.
// Assumes: purely combinational use; outputs settle within the bus cycle.
module status_io_port_decoder #(
    parameter int ADDR_W       = 8,
    parameter int SEL_W        = 3,
    parameter int INT_GRP_SIZE = 4
) (
    input  logic [ADDR_W-1:0]     addr_hi,
    input  logic                  st_inp,
    input  logic                  st_out,
    input  logic                  dbin,
    input  logic                  wr_n,
    input  logic                  inta,
    input  logic                  inta_gate_en,
    output logic [(1<<SEL_W)-1:0] in_strobe_n,
    output logic [(1<<SEL_W)-1:0] out_strobe_n,
    output logic                  int_grp_sel,
    output logic                  mem_page_en
);
    import iodec_pkg::*;

    bus_qual_t        qual;
    logic             bank_hit;
    logic [SEL_W-1:0] port_sel;
    logic             rd_en;
    logic             wr_en;
    logic             in_grp;

    // Gather the bus qualifiers into one bundle
    always_comb begin
        qual = '{st_inp: st_inp, st_out: st_out, dbin: dbin, wr_n: wr_n};
    end

    iodec_addr_match #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_match (
        .addr     (addr_hi),
        .bank_hit (bank_hit),
        .port_sel (port_sel)
    );

    iodec_qualify u_qual (
        .qual         (qual),
        .bank_hit     (bank_hit),
        .inta         (inta),
        .inta_gate_en (inta_gate_en),
        .rd_en        (rd_en),
        .wr_en        (wr_en),
        .mem_en       (mem_page_en)
    );

    iodec_strobe_gen #(.SEL_W(SEL_W)) u_rd_strobes (
        .en       (rd_en),
        .sel      (port_sel),
        .strobe_n (in_strobe_n)
    );

    iodec_strobe_gen #(.SEL_W(SEL_W)) u_wr_strobes (
        .en       (wr_en),
        .sel      (port_sel),
        .strobe_n (out_strobe_n)
    );

    // Lower input ports form the interrupt group
    always_comb begin
        in_grp      = ({1'b0, port_sel} < (SEL_W+1)'(INT_GRP_SIZE));
        int_grp_sel = rd_en && in_grp;
    end
endmodule

// File: rtl/iodec_chk.sv
// Module: iodec_chk
// Property checker bound to status_io_port_decoder. Evaluated whenever any
// observed signal changes, as the block has no clock.
// Assumes: all inputs are two-state.
module iodec_chk #(
    parameter int ADDR_W       = 8,
    parameter int SEL_W        = 3,
    parameter int INT_GRP_SIZE = 4
) (
    input logic [ADDR_W-1:0]     addr_hi,
    input logic                  st_inp,
    input logic                  st_out,
    input logic                  dbin,
    input logic                  wr_n,
    input logic                  inta,
    input logic                  inta_gate_en,
    input logic [(1<<SEL_W)-1:0] in_strobe_n,
    input logic [(1<<SEL_W)-1:0] out_strobe_n,
    input logic                  int_grp_sel,
    input logic                  mem_page_en
);
    localparam int N_PORTS = 1 << SEL_W;

    // Checks on strobe legality against address and qualifiers
    always_comb begin
        // R1
        bank_miss_chk: assert (&addr_hi[ADDR_W-1:SEL_W] ||
                               (&in_strobe_n && &out_strobe_n))
            else $error("strobe asserted outside port bank");
        // R2
        in_onehot_chk: assert ($onehot0(~in_strobe_n))
            else $error("input strobes not one-hot");
        // R2
        out_onehot_chk: assert ($onehot0(~out_strobe_n))
            else $error("output strobes not one-hot");
        // R3
        in_qual_chk: assert (&in_strobe_n || (st_inp && dbin))
            else $error("input strobe without read qualification");
        // R4
        out_qual_chk: assert (&out_strobe_n || (st_out && !wr_n))
            else $error("output strobe without write qualification");
        // R5
        int_grp_chk: assert (!int_grp_sel ||
                             ($countones(~in_strobe_n[INT_GRP_SIZE-1:0]) == 1))
            else $error("interrupt group flag without low input port");
        // R6
        ack_block_chk: assert (!(inta_gate_en && inta) ||
                               (&in_strobe_n && &out_strobe_n &&
                                !int_grp_sel && !mem_page_en))
            else $error("outputs active during blocked acknowledge");
        // R7
        mem_io_chk: assert (!(st_inp || st_out) || !mem_page_en)
            else $error("memory page enabled during I/O status");
    end

    // Sanity on the strobe width relationship
    initial begin
        width_chk: assert (N_PORTS == $bits(in_strobe_n))
            else $error("strobe width mismatch");
    end
endmodule

bind status_io_port_decoder iodec_chk #(
    .ADDR_W       (ADDR_W),
    .SEL_W        (SEL_W),
    .INT_GRP_SIZE (INT_GRP_SIZE)
) u_chk (.*);

// File: tb/status_io_port_decoder_tb.sv
// Bench: directed scenarios for status_io_port_decoder, one task each.
module status_io_port_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic [7:0] addr_hi = 8'h00;
    logic       st_inp = 1'b0, st_out = 1'b0, dbin = 1'b0, wr_n = 1'b1;
    logic       inta = 1'b0, inta_gate_en = 1'b0;
    logic [7:0] in_strobe_n, out_strobe_n;
    logic       int_grp_sel, mem_page_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_io_port_decoder u_dut (
        .addr_hi      (addr_hi),
        .st_inp       (st_inp),
        .st_out       (st_out),
        .dbin         (dbin),
        .wr_n         (wr_n),
        .inta         (inta),
        .inta_gate_en (inta_gate_en),
        .in_strobe_n  (in_strobe_n),
        .out_strobe_n (out_strobe_n),
        .int_grp_sel  (int_grp_sel),
        .mem_page_en  (mem_page_en)
    );

    // Drive one input pattern at the falling edge, settle before sampling
    task automatic apply(input logic [7:0] a, input logic i, input logic o,
                         input logic d, input logic w, input logic ack,
                         input logic strap);
        @(negedge clk);
        addr_hi = a; st_inp = i; st_out = o; dbin = d; wr_n = w;
        inta = ack; inta_gate_en = strap;
        #(CLK_PERIOD/4);
    endtask

    task automatic check8(input string tag, input logic [7:0] act,
                          input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, addr_hi, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h act=%b exp=%b", tag, addr_hi, act, exp);
        end
    endtask

    // Compare all outputs with values derived from the requirements
    task automatic check_all(input string tag);
        logic blk, bank, ie, oe;
        logic [7:0] e_in, e_out;
        blk   = inta_gate_en && inta;                 // R6
        bank  = (addr_hi[7:3] == 5'b11111);           // R1
        ie    = bank && st_inp && dbin && !blk;       // R3
        oe    = bank && st_out && !wr_n && !blk;      // R4
        e_in  = ie ? ~(8'b1 << addr_hi[2:0]) : 8'hFF; // R2
        e_out = oe ? ~(8'b1 << addr_hi[2:0]) : 8'hFF; // R2
        check8({tag, " in_strobe_n"},  in_strobe_n,  e_in);
        check8({tag, " out_strobe_n"}, out_strobe_n, e_out);
        check1({tag, " int_grp_sel"},  int_grp_sel,  ie && (addr_hi[2:0] < 3'd4)); // R5
        check1({tag, " mem_page_en"},  mem_page_en,  !st_inp && !st_out && !blk);  // R7
    endtask

    // R8: idle bus, several addresses
    task automatic t_idle();
        apply(8'hF8, 0, 0, 0, 1, 0, 0);
        check8("R8 idle in",  in_strobe_n,  8'hFF);
        check8("R8 idle out", out_strobe_n, 8'hFF);
        check1("R8 idle int", int_grp_sel,  1'b0);
        check1("R7 idle mem", mem_page_en,  1'b1);
        apply(8'hFF, 0, 0, 0, 1, 0, 0);
        check8("R8 idle FF in", in_strobe_n, 8'hFF);
    endtask

    // R1 R2 R3 R5: directed input reads at bank edges
    task automatic t_input_edges();
        apply(8'hF8, 1, 0, 1, 1, 0, 0);
        check8("R2 in F8", in_strobe_n, 8'hFE);
        check1("R5 int F8", int_grp_sel, 1'b1);
        apply(8'hFB, 1, 0, 1, 1, 0, 0);
        check1("R5 int FB", int_grp_sel, 1'b1);
        apply(8'hFC, 1, 0, 1, 1, 0, 0);
        check8("R2 in FC", in_strobe_n, 8'hEF);
        check1("R5 int FC", int_grp_sel, 1'b0);
        apply(8'hFF, 1, 0, 1, 1, 0, 0);
        check8("R2 in FF", in_strobe_n, 8'h7F);
        apply(8'hF7, 1, 0, 1, 1, 0, 0);
        check8("R1 in F7", in_strobe_n, 8'hFF);
        apply(8'h78, 1, 0, 1, 1, 0, 0);
        check8("R1 in 78", in_strobe_n, 8'hFF);
    endtask

    // R4 R5: directed output writes
    task automatic t_output_edges();
        apply(8'hF9, 0, 1, 0, 0, 0, 0);
        check8("R4 out F9", out_strobe_n, 8'hFD);
        check1("R5 no int on out", int_grp_sel, 1'b0);
        check1("R7 mem out", mem_page_en, 1'b0);
        apply(8'hF9, 0, 1, 0, 1, 0, 0);
        check8("R4 out wr_n high", out_strobe_n, 8'hFF);
        apply(8'hEE, 0, 1, 0, 0, 0, 0);
        check8("R1 out EE", out_strobe_n, 8'hFF);
    endtask

    // R3 R4: partial qualification
    task automatic t_partial();
        apply(8'hFA, 1, 0, 0, 1, 0, 0);
        check8("R3 no dbin", in_strobe_n, 8'hFF);
        apply(8'hFA, 0, 0, 1, 1, 0, 0);
        check8("R3 no st_inp", in_strobe_n, 8'hFF);
        apply(8'hFA, 0, 0, 1, 0, 0, 0);
        check8("R4 no st_out", out_strobe_n, 8'hFF);
    endtask

    // R6: acknowledge block with and without strap
    task automatic t_ack();
        apply(8'hF8, 1, 1, 1, 0, 1, 1);
        check8("R6 blk in",  in_strobe_n,  8'hFF);
        check8("R6 blk out", out_strobe_n, 8'hFF);
        check1("R6 blk int", int_grp_sel,  1'b0);
        apply(8'h00, 0, 0, 0, 1, 1, 1);
        check1("R6 blk mem", mem_page_en, 1'b0);
        apply(8'hF8, 1, 1, 1, 0, 1, 0);
        check8("R6 no strap in",  in_strobe_n,  8'hFE);
        check8("R6 no strap out", out_strobe_n, 8'hFE);
        apply(8'h00, 0, 0, 0, 1, 1, 0);
        check1("R6 no strap mem", mem_page_en, 1'b1);
    endtask

    // R1..R7: sweep all addresses against every qualifier/ack combination
    task automatic t_sweep();
        for (int c = 0; c < 64; c++) begin
            for (int a = 0; a < 256; a++) begin
                apply(8'(a), c[0], c[1], c[2], c[3], c[4], c[5]);
                check_all("R1-sweep R2 R3 R4 R5 R6 R7");
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_idle();
        t_input_edges();
        t_output_edges();
        t_partial();
        t_ack();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule